// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Address Front End

This block sits at the edge of a serial memory slave on a two-wire bus, where the lines are SCL (clock) and SDA (data). It samples both lines with the system clock and recognises start and stop conditions. After each start it shifts in the first byte. That byte is accepted only when its upper nibble carries the fixed device-type code and its next three bits equal the three strap inputs. An accepted byte is acknowledged by pulling SDA low. The lowest bit of the byte gives the transfer direction.

For a write, the two bytes that follow form a 16-bit word address, most significant byte first, and the block acknowledges each of them. Once the low byte is in, the block raises a single-cycle strobe. On that same cycle the full address appears on the output. A read that follows a repeated start keeps the address already captured and only updates the direction. Data transfer and the memory array belong to blocks further in.

The SDA output is a pull-down enable. The pad drives the line low when it is 1 and leaves it floating when it is 0.

Top module: `twi_mem_addr_front`

## Requirements
- R1: A start is SDA falling while SCL is high. It always restarts reception of the control byte from its first bit, even in the middle of a byte or during an address byte.
- R2: When the control byte has bits [7:4] = 4'b1010 and bits [3:1] = `strap_sel`, the block pulls SDA low during the ninth clock. The pull-down begins after the SCL falling edge that ends the eighth bit and is released after the SCL falling edge that ends the ninth clock.
- R3: When either field of the control byte mismatches, the block does not acknowledge and does not drive SDA for the rest of the transfer. It keeps `word_addr`, `dir_read` and `addr_valid` unchanged until the next start.
- R4: On an accepted control byte, `dir_read` takes bit 0 of that byte, where 1 means read and 0 means write.
- R5: After an accepted write control byte, the block receives two address bytes and acknowledges each one. The first byte supplies address bits 15..8 and the second supplies bits 7..0.
- R6: After the low address byte, `addr_valid` is high for exactly one clock cycle. In that same cycle `word_addr` shows all 16 received bits, and every bit is significant.
- R7: An accepted read control byte leaves `word_addr` unchanged and produces no `addr_valid`. No address bytes are expected after it, and the block does not drive SDA for the bytes that follow.
- R8: A stop, which is SDA rising while SCL is high, returns the block to idle and releases SDA. An address sequence cut short by a stop produces no `addr_valid`.
- R9: After reset, `sda_pull`, `addr_valid`, `dir_read` and `word_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap_sel | input | 3 | Pin-strapped select code that the control byte must match |
| sda_pull | output | 1 | 1 drives SDA low (acknowledge), 0 releases the line |
| word_addr | output | 16 | Last captured word address |
| dir_read | output | 1 | Direction of the last accepted control byte (1 = read) |
| addr_valid | output | 1 | One-cycle strobe marking a newly captured address |

## Verification
The hardest case to reach is a start that arrives while a byte is half shifted in. Reaching it needs an open-drain master model that can break a byte off after a few bits and raise SCL again with SDA high. The bench issues a start, clocks four bits of a byte, and then issues a repeated start. It then sends a full write sequence and checks that the acknowledge is present and that the captured address is exact. A second hard case is a read after a repeated start. There the bench confirms that the previously written address persists, that no strobe appears, and that SDA stays undriven during the following byte.

// File: rtl/twi_addr_pkg.sv
package twi_addr_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 2 * BYTE_W;
    localparam int SEL_W    = 3;
    localparam int CODE_W   = BYTE_W - SEL_W - 1;
    localparam logic [CODE_W-1:0] DEV_CODE = 4'b1010;
    localparam int CNT_W    = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ACK_CTRL,
        ST_ADDR_HI,
        ST_ACK_HI,
        ST_ADDR_LO,
        ST_ACK_LO,
        ST_DONE
    } fsm_e;

    typedef struct packed {
        fsm_e              st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] hi;
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              pull;
        logic              valid;
    } eng_s;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q <= '1;
                else        ff_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q <= '1;
                else        ff_q <= {ff_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s;
            sda_p_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_p_q;
    assign scl_fall = ~scl_s & scl_p_q;
    assign start_p  = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_p   = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/twi_addr_engine.sv
module twi_addr_engine
    import twi_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              sda_s,
    input  logic [SEL_W-1:0]  strap_sel,
    output logic              pull,
    output logic [ADDR_W-1:0] addr,
    output logic              rd,
    output logic              valid
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    eng_s e_d, e_q;
    logic byte_end;
    logic ctrl_hit;

    assign byte_end = scl_fall && (e_q.cnt == FULL);
    assign ctrl_hit = (e_q.shreg[BYTE_W-1 -: CODE_W] == DEV_CODE) &&
                      (e_q.shreg[SEL_W:1] == strap_sel);

    always_comb begin
        e_d       = e_q;
        e_d.valid = 1'b0;
        if (start_p) begin
            e_d.st   = ST_CTRL;
            e_d.cnt  = '0;
            e_d.pull = 1'b0;
        end else if (stop_p) begin
            e_d.st   = ST_IDLE;
            e_d.cnt  = '0;
            e_d.pull = 1'b0;
        end else begin
            unique case (e_q.st)
                ST_CTRL, ST_ADDR_HI, ST_ADDR_LO: begin
                    if (scl_rise && e_q.cnt != FULL) begin
                        e_d.shreg = {e_q.shreg[BYTE_W-2:0], sda_s};
                        e_d.cnt   = e_q.cnt + 1'b1;
                    end else if (byte_end) begin
                        e_d.cnt = '0;
                        if (e_q.st == ST_CTRL) begin
                            if (ctrl_hit) begin
                                e_d.st   = ST_ACK_CTRL;
                                e_d.pull = 1'b1;
                                e_d.rd   = e_q.shreg[0];
                            end else begin
                                e_d.st = ST_IDLE;
                            end
                        end else if (e_q.st == ST_ADDR_HI) begin
                            e_d.st   = ST_ACK_HI;
                            e_d.pull = 1'b1;
                            e_d.hi   = e_q.shreg;
                        end else begin
                            e_d.st    = ST_ACK_LO;
                            e_d.pull  = 1'b1;
                            e_d.addr  = {e_q.hi, e_q.shreg};
                            e_d.valid = 1'b1;
                        end
                    end
                end
                ST_ACK_CTRL: begin
                    if (scl_fall) begin
                        e_d.pull = 1'b0;
                        e_d.st   = e_q.rd ? ST_DONE : ST_ADDR_HI;
                    end
                end
                ST_ACK_HI: begin
                    if (scl_fall) begin
                        e_d.pull = 1'b0;
                        e_d.st   = ST_ADDR_LO;
                    end
                end
                ST_ACK_LO: begin
                    if (scl_fall) begin
                        e_d.pull = 1'b0;
                        e_d.st   = ST_DONE;
                    end
                end
                default: begin
                    e_d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{st: ST_IDLE, cnt: '0, shreg: '0, hi: '0, addr: '0,
                     rd: 1'b0, pull: 1'b0, valid: 1'b0};
        end else begin
            e_q <= e_d;
        end
    end

    assign pull  = e_q.pull;
    assign addr  = e_q.addr;
    assign rd    = e_q.rd;
    assign valid = e_q.valid;
endmodule

// File: rtl/twi_mem_addr_front.sv
module twi_mem_addr_front
    import twi_addr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [SEL_W-1:0]  strap_sel,
    output logic              sda_pull,
    output logic [ADDR_W-1:0] word_addr,
    output logic              dir_read,
    output logic              addr_valid
);
    logic scl_s, sda_s;
    logic scl_rise_w, scl_fall_w, start_w, stop_w;

    twi_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
    twi_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

    twi_bus_events u_evt (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
        .start_p(start_w), .stop_p(stop_w));

    twi_addr_engine u_eng (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
        .start_p(start_w), .stop_p(stop_w), .sda_s(sda_s),
        .strap_sel(strap_sel),
        .pull(sda_pull), .addr(word_addr), .rd(dir_read), .valid(addr_valid));
endmodule

// File: rtl/twi_mem_addr_front_chk.sv
module twi_mem_addr_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_fall,
    input logic        start_p,
    input logic        stop_p,
    input logic        pull,
    input logic        valid,
    input logic [15:0] addr,
    input logic        rd
);
    // R2
    ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull) |-> $past(scl_fall));

    // R2
    release_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull) |-> ($past(scl_fall) || $past(start_p) || $past(stop_p)));

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !pull);

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6
    valid_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> pull);

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(addr));

    // R4
    dir_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd) |-> $past(scl_fall));
endmodule

bind twi_mem_addr_front twi_mem_addr_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall_w), .start_p(start_w),
    .stop_p(stop_w), .pull(sda_pull), .valid(addr_valid),
    .addr(word_addr), .rd(dir_read));

// File: tb/twi_mem_addr_front_tb.sv
module twi_mem_addr_front_tb;
    localparam time CLK_P = 10ns;
    localparam int  Q     = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic        sda_pull;
    logic [15:0] word_addr;
    logic        dir_read;
    logic        addr_valid;
    logic        sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int v_cnt = 0;
    logic [15:0] v_addr = '0;
    logic v_prev = 1'b0;
    int v_wide = 0;
    int cyc = 0;

    assign sda_bus = sda_m & ~sda_pull;

    always #(CLK_P/2) clk = ~clk;

    twi_mem_addr_front u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .strap_sel(strap), .sda_pull(sda_pull), .word_addr(word_addr),
        .dir_read(dir_read), .addr_valid(addr_valid));

    always @(negedge clk) begin
        if (addr_valid) begin
            v_cnt++;
            v_addr = word_addr;
            if (v_prev) v_wide++;
        end
        v_prev = addr_valid;
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b0; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b1; wq(2);
    endtask

    task automatic clock_bit(input logic b, output logic seen, output logic drv);
        sda_m = b; wq(1);
        scl_m = 1'b1; wq(1);
        seen = sda_bus;
        drv  = sda_pull;
        wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked,
                             output bit drove, output bit held);
        logic seen, d;
        drove = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(b[i], seen, d);
            drove |= d;
        end
        clock_bit(1'b1, seen, d);
        acked = !seen;
        drove |= d;
        held = sda_pull;
    endtask

    task automatic partial_bits(input logic [3:0] b);
        logic seen, d;
        for (int i = 3; i >= 0; i--) clock_bit(b[i], seen, d);
    endtask

    task automatic t_reset();
        check(sda_pull == 1'b0, "R9 pull", sda_pull, 0);
        check(addr_valid == 1'b0, "R9 valid", addr_valid, 0);
        check(word_addr == 16'h0, "R9 addr", word_addr, 0);
        check(dir_read == 1'b0, "R9 dir", dir_read, 0);
    endtask

    task automatic t_write(input logic [15:0] a, input string tag);
        bit ak, dv, hd;
        int v0 = v_cnt;
        bus_start();
        send_byte({4'b1010, strap, 1'b0}, ak, dv, hd);
        check(ak, {"R2 ctrl ack ", tag}, ak, 1);
        check(!hd, {"R2 ack release ", tag}, hd, 0);
        check(dir_read == 1'b0, {"R4 write dir ", tag}, dir_read, 0);
        send_byte(a[15:8], ak, dv, hd);
        check(ak, {"R5 hi ack ", tag}, ak, 1);
        check(v_cnt == v0, {"R6 no early valid ", tag}, v_cnt, v0);
        send_byte(a[7:0], ak, dv, hd);
        check(ak, {"R5 lo ack ", tag}, ak, 1);
        check(v_cnt == v0 + 1, {"R6 valid count ", tag}, v_cnt, v0 + 1);
        check(v_addr == a, {"R6 strobe addr ", tag}, v_addr, a);
        check(word_addr == a, {"R6 held addr ", tag}, word_addr, a);
        bus_stop();
        check(sda_pull == 1'b0, {"R8 idle after stop ", tag}, sda_pull, 0);
    endtask

    task automatic t_mismatch(input logic [7:0] ctrl, input string tag);
        bit ak, dv, hd;
        int v0 = v_cnt;
        logic [15:0] a0 = word_addr;
        logic d0 = dir_read;
        bus_start();
        send_byte(ctrl, ak, dv, hd);
        check(!ak && !dv, {"R3 no ack ", tag}, ak, 0);
        send_byte(8'h12, ak, dv, hd);
        send_byte(8'h34, ak, dv, hd);
        check(!dv, {"R3 no drive ", tag}, dv, 0);
        check(v_cnt == v0 && word_addr == a0, {"R3 addr kept ", tag}, word_addr, a0);
        check(dir_read == d0, {"R3 dir kept ", tag}, dir_read, d0);
        bus_stop();
    endtask

    task automatic t_read_after_restart();
        bit ak, dv, hd;
        int v0;
        bus_start();
        send_byte({4'b1010, strap, 1'b0}, ak, dv, hd);
        send_byte(8'h12, ak, dv, hd);
        send_byte(8'h34, ak, dv, hd);
        v0 = v_cnt;
        bus_start();
        send_byte({4'b1010, strap, 1'b1}, ak, dv, hd);
        check(ak, "R2 read ctrl ack", ak, 1);
        check(dir_read == 1'b1, "R4 read dir", dir_read, 1);
        send_byte(8'hFF, ak, dv, hd);
        check(!dv, "R7 no drive after read ctrl", dv, 0);
        check(word_addr == 16'h1234 && v_cnt == v0, "R7 addr kept", word_addr, 16'h1234);
        bus_stop();
    endtask

    task automatic t_abort_mid_byte();
        bus_start();
        partial_bits(4'b1010);
        t_write(16'h0F0E, "R1 after abort");
    endtask

    task automatic t_stop_mid_addr();
        bit ak, dv, hd;
        int v0 = v_cnt;
        logic [15:0] a0 = word_addr;
        bus_start();
        send_byte({4'b1010, strap, 1'b0}, ak, dv, hd);
        send_byte(8'hAB, ak, dv, hd);
        bus_stop();
        send_byte(8'hCD, ak, dv, hd);
        check(!ak && !dv, "R8 no ack after stop", ak, 0);
        check(v_cnt == v0 && word_addr == a0, "R8 no valid after stop", word_addr, a0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_write(16'hA53C, "A53C");
        t_mismatch({4'b1010, 3'b011, 1'b0}, "sel");
        t_mismatch({4'b1011, 3'b101, 1'b0}, "code");
        t_write(16'hFFFF, "FFFF");
        t_write(16'h0001, "0001");
        strap = 3'b000;
        t_write(16'h8000, "sel000");
        t_mismatch({4'b1010, 3'b101, 1'b0}, "old sel");
        t_read_after_restart();
        t_abort_mid_byte();
        t_stop_mid_addr();
        check(v_wide == 0, "R6 single cycle strobe", v_wide, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule